// File: doc/BRIEF.md
# Cascadable LCD Segment Column Driver

This block is the data path of a column driver for a dot-matrix liquid-crystal panel. It has 320 channels. Pixel data arrives on a 4-bit or 8-bit bus, one chunk on each falling edge of a shift strobe. An internal group pointer steers each chunk into a capture buffer, four channels per group. When a row strobe falls, the block copies the whole buffer into a row latch. Each channel then drives a 2-bit level code. The code is set by the latched pixel, an AC polarity input and a display-off input. Analog level shifting and the panel voltages are not part of this block.

Several chips share one data bus and form a chain through an active-low enable token. A chip accepts data only while its enable input is low. After its last group is filled, it pulls its enable output low so the next chip takes over. Other inputs can reverse the channel order and select a reduced 240-channel mode.

Both strobes are sampled in the `clk` domain. A strobe edge is seen at the first rising clock edge at which the strobe reads low after having read high. A three-state machine runs the token:
- `ST_ARMED` accepts chunks. It moves to `ST_HANDOFF` on the chunk that fills the last group.
- `ST_HANDOFF` holds the enable output low. It moves to `ST_SPENT` on the next shift-strobe fall.
- `ST_SPENT` ignores data.
- A row-strobe fall returns any state to `ST_ARMED`, and it takes priority over a shift-strobe fall in the same cycle.

Top module: `lcdseg_driver`

## Requirements
- R1: On each shift-strobe fall that is accepted, `data_in[3:0]` fills group `g`, with bit `k` going to buffer position `4g+k`. When `wide_bus`=1, `data_in[7:4]` also fills group `g+1`, and the pointer advances by 2 instead of 1. When `wide_bus`=0, `data_in[7:4]` has no effect.
- R2: A row-strobe fall copies the capture buffer into the row latch. The channel outputs do not change between row-strobe falls unless `disp_on`, `m_pol` or `full_width` change.
- R3: Chunks are captured only while `en_in_n` is low. A shift-strobe fall while `en_in_n` is high moves neither the pointer nor the buffer.
- R4: `en_out_n` goes low on the shift-strobe fall that fills the last group. It stays low until the next shift-strobe fall, and then returns high. After that, chunks are ignored until the next row-strobe fall.
- R5: A row-strobe fall sets `en_out_n` high and returns the pointer to the first group of the current mode.
- R6: With `shift_rev`=0 at the row-strobe fall, channel `i` shows buffer position `i`. With `shift_rev`=1, it shows position `319-i`.
- R7: With `full_width`=0, the pointer covers groups 10 to 69 only (60 groups), and the token passes after those 60 groups. Channels 0-39 and 280-319 (0-based) always drive the not-selected level, which is the level of a pixel 0.
- R8: Channel `i` is `seg_code[2i+1:2i]`. The codes are 2'b00 = V0, 2'b01 = VM and 2'b10 = V1. With display on, the output is V0 for (pixel 0, `m_pol` 0) or (pixel 1, `m_pol` 1), and V1 for the other two pairs. Code 2'b11 never appears.
- R9: While `disp_on` is low, every channel drives VM, whatever the pixel or `m_pol`.
- R10: An active-low asynchronous `rst_n` clears the buffer and the row latch to zero, sets `en_out_n` high and puts the pointer at the first group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all state |
| rst_n | input | 1 | Asynchronous reset, active low |
| cl2 | input | 1 | Shift strobe; a falling edge captures a chunk |
| cl1 | input | 1 | Row strobe; a falling edge loads the row latch |
| data_in | input | 8 | Pixel chunk |
| wide_bus | input | 1 | 1 = 8-bit chunks, 0 = 4-bit chunks |
| full_width | input | 1 | 1 = 320 channels, 0 = 240-channel mode |
| shift_rev | input | 1 | Reverses the channel order at the row load |
| en_in_n | input | 1 | Enable token in, active low |
| en_out_n | output | 1 | Enable token out to the next chip, active low |
| disp_on | input | 1 | 0 forces every channel to VM |
| m_pol | input | 1 | AC polarity of the drive |
| seg_code | output | 640 | Level code, 2 bits per channel |

## Verification
The assertions assume that `cl1`, `cl2`, `en_in_n` and the mode inputs change only between clock edges. They also assume that each strobe stays low for at least one full clock period, so that every fall is seen exactly once. The bench drives every input on the falling clock edge and holds each strobe low for one whole period. It changes `wide_bus`, `full_width` and `shift_rev` only while the chip is between rows, so the pointer never straddles two modes.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_VM = 2'b01,
        LVL_V1 = 2'b10
    } lvl_t;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'b00,
        ST_HANDOFF = 2'b01,
        ST_SPENT   = 2'b10
    } tok_state_t;
endpackage

// File: rtl/lcdseg_fall.sv
module lcdseg_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);
    logic sig_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_d <= 1'b0;
        else        sig_d <= sig;
    end

    assign fall = sig_d & ~sig;
endmodule

// File: rtl/lcdseg_capture.sv
module lcdseg_capture
    import lcdseg_pkg::*;
#(
    parameter int NCH     = 320,
    parameter int GW      = 4,
    parameter int SKIP_CH = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cl2_fall,
    input  logic            cl1_fall,
    input  logic            wide,
    input  logic            full,
    input  logic            en_in_n,
    input  logic [2*GW-1:0] data,
    output logic [NCH-1:0]  cap,
    output logic            en_out_n
);
    localparam int NGRP  = NCH / GW;
    localparam int SKIPG = SKIP_CH / GW;
    localparam int PW    = $clog2(NGRP + 2);
    localparam logic [PW-1:0] SPAN_FULL  = PW'(NGRP);
    localparam logic [PW-1:0] SPAN_SHORT = PW'(NGRP - 2 * SKIPG);
    localparam logic [PW-1:0] BASE_SHORT = PW'(SKIPG);

    tok_state_t st, st_nx;
    logic [PW-1:0] rel, span, base, step, grp;
    logic take, last_fill;

    always_comb begin
        span      = full ? SPAN_FULL : SPAN_SHORT;
        base      = full ? '0 : BASE_SHORT;
        step      = wide ? PW'(2) : PW'(1);
        grp       = base + rel;
        take      = cl2_fall && !cl1_fall && !en_in_n && (st == ST_ARMED);
        last_fill = (rel + step) >= span;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_ARMED;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_ARMED:   if (take && last_fill) st_nx = ST_HANDOFF;
            ST_HANDOFF: if (cl2_fall)          st_nx = ST_SPENT;
            ST_SPENT:   st_nx = ST_SPENT;
            default:    st_nx = ST_ARMED;
        endcase
        if (cl1_fall) st_nx = ST_ARMED;
    end

    // outputs
    always_comb begin
        en_out_n = (st != ST_HANDOFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rel <= '0;
        else if (cl1_fall) rel <= '0;
        else if (take)     rel <= rel + step;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [PW-1:0] GI = PW'(g);
        logic [GW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= '0;
            else if (take && grp == GI)                q <= data[GW-1:0];
            else if (take && wide && grp + PW'(1) == GI) q <= data[2*GW-1:GW];
        end
        assign cap[g*GW +: GW] = q;
    end
endmodule

// File: rtl/lcdseg_drive.sv
module lcdseg_drive
    import lcdseg_pkg::*;
#(
    parameter int NCH     = 320,
    parameter int SKIP_CH = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             rev,
    input  logic             full,
    input  logic             disp_on,
    input  logic             m_pol,
    input  logic [NCH-1:0]   cap,
    output logic [2*NCH-1:0] seg_code
);
    logic [NCH-1:0] row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row <= '0;
        else if (load) begin
            for (int i = 0; i < NCH; i++) row[i] <= rev ? cap[NCH-1-i] : cap[i];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam bit OUTER = (i < SKIP_CH) || (i >= NCH - SKIP_CH);
        logic pix;
        lvl_t lv;
        always_comb begin
            pix = row[i] & (full | !OUTER);
            if (!disp_on)          lv = LVL_VM;
            else if (pix ^ m_pol)  lv = LVL_V1;
            else                   lv = LVL_V0;
        end
        assign seg_code[2*i +: 2] = lv;
    end
endmodule

// File: rtl/lcdseg_driver.sv
module lcdseg_driver
    import lcdseg_pkg::*;
#(
    parameter int NCH     = 320,
    parameter int GW      = 4,
    parameter int SKIP_CH = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cl2,
    input  logic             cl1,
    input  logic [2*GW-1:0]  data_in,
    input  logic             wide_bus,
    input  logic             full_width,
    input  logic             shift_rev,
    input  logic             en_in_n,
    output logic             en_out_n,
    input  logic             disp_on,
    input  logic             m_pol,
    output logic [2*NCH-1:0] seg_code
);
    logic c2f, c1f;
    logic [NCH-1:0] cap;

    lcdseg_fall u_c2 (.clk(clk), .rst_n(rst_n), .sig(cl2), .fall(c2f));
    lcdseg_fall u_c1 (.clk(clk), .rst_n(rst_n), .sig(cl1), .fall(c1f));

    lcdseg_capture #(.NCH(NCH), .GW(GW), .SKIP_CH(SKIP_CH)) u_cap (
        .clk(clk), .rst_n(rst_n), .cl2_fall(c2f), .cl1_fall(c1f),
        .wide(wide_bus), .full(full_width), .en_in_n(en_in_n),
        .data(data_in), .cap(cap), .en_out_n(en_out_n)
    );

    lcdseg_drive #(.NCH(NCH), .SKIP_CH(SKIP_CH)) u_drv (
        .clk(clk), .rst_n(rst_n), .load(c1f), .rev(shift_rev),
        .full(full_width), .disp_on(disp_on), .m_pol(m_pol),
        .cap(cap), .seg_code(seg_code)
    );
endmodule

// File: rtl/lcdseg_checker.sv
module lcdseg_checker #(
    parameter int NCH = 320
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cl1,
    input logic             cl2,
    input logic             en_in_n,
    input logic             en_out_n,
    input logic             disp_on,
    input logic             m_pol,
    input logic             full_width,
    input logic [2*NCH-1:0] seg_code
);
    logic c1d, c2d, c1f, c2f, illegal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1d <= 1'b0;
            c2d <= 1'b0;
        end else begin
            c1d <= cl1;
            c2d <= cl2;
        end
    end
    assign c1f = c1d & ~cl1;
    assign c2f = c2d & ~cl2;

    always_comb begin
        illegal = 1'b0;
        for (int i = 0; i < NCH; i++) if (seg_code[2*i +: 2] == 2'b11) illegal = 1'b1;
    end

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal); // R8
    AST_DISP_OFF_VM: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> seg_code == {NCH{2'b01}}); // R9
    AST_TOKEN_ON_CL2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_out_n) |-> $past(c2f)); // R4
    AST_TOKEN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_out_n) |-> $past(!en_in_n)); // R3
    AST_RELEASE_ON_CL1: assert property (@(posedge clk) disable iff (!rst_n)
        c1f |=> en_out_n); // R5
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(c1f) && $stable(disp_on) && $stable(m_pol) && $stable(full_width))
        |-> $stable(seg_code)); // R2
endmodule

bind lcdseg_driver lcdseg_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cl1(cl1), .cl2(cl2), .en_in_n(en_in_n),
    .en_out_n(en_out_n), .disp_on(disp_on), .m_pol(m_pol),
    .full_width(full_width), .seg_code(seg_code)
);

// File: tb/sim_lcdseg_driver.sv
module sim_lcdseg_driver;
    localparam int CLK_P = 10;
    localparam int NCH   = 320;
    localparam int SKIP  = 40;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic rst_n, cl2, cl1, wide_bus, full_width, shift_rev, en_in_n, en_out_n, disp_on, m_pol;
    logic [7:0] data_in;
    logic [2*NCH-1:0] seg_code;

    lcdseg_driver u0 (
        .clk(clk), .rst_n(rst_n), .cl2(cl2), .cl1(cl1), .data_in(data_in),
        .wide_bus(wide_bus), .full_width(full_width), .shift_rev(shift_rev),
        .en_in_n(en_in_n), .en_out_n(en_out_n), .disp_on(disp_on),
        .m_pol(m_pol), .seg_code(seg_code)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic [NCH-1:0] model_cap = '0;
    logic [NCH-1:0] row_exp = '0;

    function automatic logic [NCH-1:0] reorder(logic [NCH-1:0] c, bit r);
        logic [NCH-1:0] o;
        for (int i = 0; i < NCH; i++) o[i] = r ? c[NCH-1-i] : c[i];
        return o;
    endfunction

    function automatic logic [2*NCH-1:0] exp_seg(logic [NCH-1:0] row, bit f, bit d, bit m);
        logic [2*NCH-1:0] s;
        for (int i = 0; i < NCH; i++) begin
            bit p = row[i];
            if (!f && (i < SKIP || i >= NCH - SKIP)) p = 0;
            s[2*i +: 2] = !d ? 2'b01 : ((p ^ m) ? 2'b10 : 2'b00);
        end
        return s;
    endfunction

    task automatic chk(input string req, input logic [2*NCH-1:0] act, input logic [2*NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic c2_pulse(input logic [7:0] d);
        @(negedge clk); data_in = d; cl2 = 1'b0;
        @(negedge clk); cl2 = 1'b1;
    endtask

    task automatic c1_pulse;
        @(negedge clk); cl1 = 1'b0;
        @(negedge clk); cl1 = 1'b1;
    endtask

    // n < 0 sends a complete row; accept says whether the chunks should land
    task automatic send_row(input bit wide, input bit full, input int n, input bit accept);
        int step  = wide ? 2 : 1;
        int first = full ? 0 : 10;
        int cnt   = (full ? 80 : 60) / step;
        if (n >= 0) cnt = n;
        wide_bus = wide; full_width = full;
        for (int k = 0; k < cnt; k++) begin
            logic [7:0] d = 8'($urandom);
            int g = first + k * step;
            c2_pulse(d);
            if (accept) begin
                model_cap[4*g +: 4] = d[3:0];
                if (wide) model_cap[4*(g+1) +: 4] = d[7:4];
            end
        end
    endtask

    task automatic latch_and_check(input string req, input bit rev);
        shift_rev = rev;
        c1_pulse;
        row_exp = reorder(model_cap, rev);
        chk({req, " R5 token released"}, {639'b0, en_out_n}, {639'b0, 1'b1});
        for (int c = 0; c < 4; c++) begin
            disp_on = c[1]; m_pol = c[0];
            #1;
            chk({req, (c < 2) ? " R9" : " R8"}, seg_code, exp_seg(row_exp, full_width, disp_on, m_pol));
        end
        disp_on = 1'b1; m_pol = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R4 actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 0; cl1 = 1; cl2 = 1; data_in = 0; wide_bus = 1; full_width = 1;
        shift_rev = 0; en_in_n = 0; disp_on = 1; m_pol = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R10 reset codes", seg_code, '0);
        chk("R10 reset token", {639'b0, en_out_n}, {639'b0, 1'b1});

        // 4-bit bus, upper bits random and ignored
        send_row(0, 1, -1, 1);
        #1 chk("R4 token low after last group", {639'b0, en_out_n}, '0);
        chk("R2 hold before row strobe", seg_code, exp_seg(row_exp, full_width, 1, 0));
        c2_pulse(8'hFF);
        #1 chk("R4 token high after next strobe", {639'b0, en_out_n}, {639'b0, 1'b1});
        latch_and_check("R1 4-bit row", 0);

        // chunks after the chip is full are dropped
        send_row(1, 1, -1, 1);
        send_row(1, 1, 4, 0);
        latch_and_check("R4 ignore after full", 0);

        // random rows in mixed modes
        for (int r = 0; r < 10; r++) begin
            bit w = 1'($urandom), f = 1'($urandom), v = 1'($urandom);
            send_row(w, f, -1, 1);
            #1 chk("R4 token low random", {639'b0, en_out_n}, '0);
            latch_and_check(f ? "R1 R6 random" : "R7 R6 random", v);
        end

        // no token, no capture
        en_in_n = 1;
        send_row(1, 1, 6, 0);
        #1 chk("R3 token stays high", {639'b0, en_out_n}, {639'b0, 1'b1});
        latch_and_check("R3 disabled row", 0);
        en_in_n = 0;
        send_row(0, 1, -1, 1);
        latch_and_check("R3 row after enable", 0);

        // partial row, then pointer restart
        send_row(1, 1, 7, 1);
        #1 chk("R5 no handoff on partial", {639'b0, en_out_n}, {639'b0, 1'b1});
        latch_and_check("R5 partial row", 0);
        send_row(1, 1, -1, 1);
        latch_and_check("R5 restart row", 1);

        // reduced mode, reversed, 4-bit
        send_row(0, 0, 59, 1);
        #1 chk("R7 no handoff at 59 groups", {639'b0, en_out_n}, {639'b0, 1'b1});
        send_row(0, 0, 1, 0);
        #1 chk("R7 handoff at 60 groups", {639'b0, en_out_n}, '0);
        model_cap[279 -: 4] = data_in[3:0];
        latch_and_check("R7 R6 reduced reversed", 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule